// File: doc/BRIEF.md
# Paged Program Counter Load Unit

This block owns the program counter of a small 8-bit controller core and works out its next value on every clock, where one clock is one instruction cycle. Without a load request the counter steps forward by one. A jump loads a 9-bit target. A subroutine call, or any instruction that writes the low counter byte, loads only 8 bits and clears bit 8. Whatever lies above bit 8 comes from the page-select bits of the status register. The counter is 9, 10 or 11 bits wide, chosen by a parameter.

The decoder drives one request line for each kind of load: return, call, jump or low-byte write. The block also receives the immediate field of the instruction, the ALU result byte, the status register byte and the return address from the stack. It outputs the current counter value and the address after it, which the stack pushes on a call. Because bit 8 is cleared on calls and computed jumps, these can only reach the lower half of a 512-word page.

Top module: `pc_load_unit`

## Requirements
- R1: A synchronous active-high reset loads the counter with the parameter `RESET_VEC` on the next edge. The default is all ones.
- R2: In a cycle with no load request, the counter becomes its value plus one, modulo 2^`PC_WIDTH`. The status page bits have no effect on this step.
- R3: With `gotoReq` high, counter bits 8:0 take `immField[8:0]`.
- R4: With `callReq` high, counter bits 7:0 take `immField[7:0]` and bit 8 becomes 0.
- R5: With `pclWrReq` high, counter bits 7:0 take `aluResult` and bit 8 becomes 0.
- R6: On a jump, call or low-byte write, counter bit 9 takes `statusReg[5]` and bit 10 takes `statusReg[6]`, where the width has those bits. All other status bits have no effect.
- R7: With `retReq` high, the whole counter takes `retAddr`, and the status bits are ignored.
- R8: `pushAddr` always equals the counter plus one, modulo 2^`PC_WIDTH`. In the cycle that a call is requested it therefore gives the address after the call.
- R9: When several requests are high together, the priority is reset, then return, then call, then jump, then low-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| retReq | input | 1 | Return: load counter from retAddr |
| callReq | input | 1 | Call request |
| gotoReq | input | 1 | Jump request |
| pclWrReq | input | 1 | Instruction writes the low counter byte |
| immField | input | 9 | Immediate field of the instruction word |
| aluResult | input | 8 | Byte written to the low counter byte |
| statusReg | input | 8 | Status register; bits 5 and 6 are page selects |
| retAddr | input | PC_WIDTH | Return address from the stack |
| pc | output | PC_WIDTH | Current program counter |
| pushAddr | output | PC_WIDTH | Counter plus one, for pushing on a call |

## Verification
Assertions check on every cycle that at most one load strobe is active and that a return always wins. They also check that each kind of load leaves the right bits in the counter on the following edge: the cleared bit 8 on calls, the page bits copied from status, the full return address, and the plain increment. Only the bench's scenarios can show that decoding follows the priority order end to end from the ports. They also show the wrap from the top address to zero with page bits set, that unrelated status bits are ignored, and that the reset vector lands.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  // One-hot load strobes from the control to the datapath.
  typedef struct packed {
    logic selRet;
    logic selCall;
    logic selGoto;
    logic selPcl;
  } pcStrobes_t;
endpackage

// File: rtl/pcl_ctrl.sv
module pcl_ctrl
  import pcl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       retReq,
  input  logic       callReq,
  input  logic       gotoReq,
  input  logic       pclWrReq,
  output pcStrobes_t strb
);
  // Fixed priority: return > call > goto > low-byte write.
  always_comb begin
    strb = '0;
    if (retReq)        strb.selRet  = 1'b1;
    else if (callReq)  strb.selCall = 1'b1;
    else if (gotoReq)  strb.selGoto = 1'b1;
    else if (pclWrReq) strb.selPcl  = 1'b1;
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst) $onehot0(strb)); // R9
  AST_RET_WINS: assert property (@(posedge clk) disable iff (rst) retReq |-> strb.selRet); // R9
  AST_CALL_OVER_GOTO: assert property (@(posedge clk) disable iff (rst)
    (callReq && !retReq) |-> (strb.selCall && !strb.selGoto)); // R9
  AST_ANY_REQ_LOADS: assert property (@(posedge clk) disable iff (rst)
    (retReq || callReq || gotoReq || pclWrReq) |-> (strb != '0)); // R9
endmodule

// File: rtl/pcl_datapath.sv
module pcl_datapath
  import pcl_pkg::*;
#(
  parameter int PC_WIDTH = 11,
  parameter logic [PC_WIDTH-1:0] RESET_VEC = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  pcStrobes_t          strb,
  input  logic [8:0]          immField,
  input  logic [7:0]          aluResult,
  input  logic [7:0]          statusReg,
  input  logic [PC_WIDTH-1:0] retAddr,
  output logic [PC_WIDTH-1:0] pc,
  output logic [PC_WIDTH-1:0] pushAddr
);
  localparam int PAGE_W = PC_WIDTH - 9;
  localparam int PAGE_LSB = 5;

  logic [8:0]          lowTarget;
  logic [PC_WIDTH-1:0] pagedTarget;
  logic [PC_WIDTH-1:0] pcNext;
  logic [PC_WIDTH-1:0] pcInc;
  logic                anyPaged;
  logic                unusedStatus;

  assign unusedStatus = ^statusReg;
  assign anyPaged = strb.selCall | strb.selGoto | strb.selPcl;
  assign pcInc = pc + 1'b1;

  // The low nine bits depend on the load kind; bit 8 is kept only for a jump.
  always_comb begin
    if (strb.selCall)      lowTarget = {1'b0, immField[7:0]};
    else if (strb.selGoto) lowTarget = immField;
    else                   lowTarget = {1'b0, aluResult};
  end

  generate
    if (PAGE_W > 0) begin : g_paged
      logic [PAGE_W-1:0] pageSel;
      assign pageSel = statusReg[PAGE_LSB +: PAGE_W];
      assign pagedTarget = {pageSel, lowTarget};

      AST_PAGE_BITS: assert property (@(posedge clk) disable iff (rst)
        anyPaged && !strb.selRet |=> pc[PC_WIDTH-1:9] == $past(statusReg[PAGE_LSB +: PAGE_W])); // R6
    end else begin : g_flat
      assign pagedTarget = lowTarget;
    end
  endgenerate

  always_comb begin
    if (strb.selRet)  pcNext = retAddr;
    else if (anyPaged) pcNext = pagedTarget;
    else              pcNext = pcInc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_VEC;
    else     pc <= pcNext;
  end

  assign pushAddr = pcInc;

  AST_RESET_VEC: assert property (@(posedge clk) rst |=> pc == RESET_VEC); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    strb == '0 |=> pc == PC_WIDTH'($past(pc) + 1'b1)); // R2
  AST_GOTO_LOW: assert property (@(posedge clk) disable iff (rst)
    strb.selGoto |=> pc[8:0] == $past(immField)); // R3
  AST_CALL_BIT8: assert property (@(posedge clk) disable iff (rst)
    strb.selCall |=> (pc[8] == 1'b0 && pc[7:0] == $past(immField[7:0]))); // R4
  AST_PCL_BIT8: assert property (@(posedge clk) disable iff (rst)
    strb.selPcl |=> (pc[8] == 1'b0 && pc[7:0] == $past(aluResult))); // R5
  AST_RET_FULL: assert property (@(posedge clk) disable iff (rst)
    strb.selRet |=> pc == $past(retAddr)); // R7
  AST_PUSH_NEXT: assert property (@(posedge clk) disable iff (rst)
    strb.selCall |=> $past(pushAddr) == PC_WIDTH'($past(pc) + 1'b1)); // R8
endmodule

// File: rtl/pc_load_unit.sv
module pc_load_unit
  import pcl_pkg::*;
#(
  parameter int PC_WIDTH = 11,
  parameter logic [PC_WIDTH-1:0] RESET_VEC = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                retReq,
  input  logic                callReq,
  input  logic                gotoReq,
  input  logic                pclWrReq,
  input  logic [8:0]          immField,
  input  logic [7:0]          aluResult,
  input  logic [7:0]          statusReg,
  input  logic [PC_WIDTH-1:0] retAddr,
  output logic [PC_WIDTH-1:0] pc,
  output logic [PC_WIDTH-1:0] pushAddr
);
  pcStrobes_t strb;

  pcl_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .retReq   (retReq),
    .callReq  (callReq),
    .gotoReq  (gotoReq),
    .pclWrReq (pclWrReq),
    .strb     (strb)
  );

  pcl_datapath #(
    .PC_WIDTH  (PC_WIDTH),
    .RESET_VEC (RESET_VEC)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .immField  (immField),
    .aluResult (aluResult),
    .statusReg (statusReg),
    .retAddr   (retAddr),
    .pc        (pc),
    .pushAddr  (pushAddr)
  );
endmodule

// File: tb/pc_load_unit_tb.sv
module pc_load_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 11;

  typedef struct {
    logic [W-1:0] expPc;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         retReq = 1'b0, callReq = 1'b0, gotoReq = 1'b0, pclWrReq = 1'b0;
  logic [8:0]   immField = '0;
  logic [7:0]   aluResult = '0;
  logic [7:0]   statusReg = '0;
  logic [W-1:0] retAddr = '0;
  logic [W-1:0] pc, pushAddr;

  expItem_t     expQ[$];
  logic [W-1:0] modelPc;
  int           nChecks = 0;
  int           nFails = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pc_load_unit dut_i (
    .clk(clk), .rst(rst), .retReq(retReq), .callReq(callReq), .gotoReq(gotoReq),
    .pclWrReq(pclWrReq), .immField(immField), .aluResult(aluResult),
    .statusReg(statusReg), .retAddr(retAddr), .pc(pc), .pushAddr(pushAddr)
  );

  // Reference next-value computation, written from the requirements.
  function automatic logic [W-1:0] refNext(logic [W-1:0] cur, logic r, logic rt, logic cl,
                                           logic gt, logic pw, logic [8:0] imm,
                                           logic [7:0] alu, logic [7:0] st, logic [W-1:0] ra);
    logic [1:0] page;
    page = {st[6], st[5]};
    if (r)       return '1;
    else if (rt) return ra;
    else if (cl) return {page, 1'b0, imm[7:0]};
    else if (gt) return {page, imm};
    else if (pw) return {page, 1'b0, alu};
    else         return cur + 1'b1;
  endfunction

  // Driver: set inputs away from the edge and queue the expected result.
  task automatic drive(logic r, logic rt, logic cl, logic gt, logic pw, logic [8:0] imm,
                       logic [7:0] alu, logic [7:0] st, logic [W-1:0] ra, string tag);
    expItem_t it;
    @(negedge clk);
    rst = r; retReq = rt; callReq = cl; gotoReq = gt; pclWrReq = pw;
    immField = imm; aluResult = alu; statusReg = st; retAddr = ra;
    modelPc = refNext(modelPc, r, rt, cl, gt, pw, imm, alu, st, ra);
    it.expPc = modelPc;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: one item is consumed after each clock edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(it.tag, pc, it.expPc);
      check("R8 pushAddr", pushAddr, W'(it.expPc + 1'b1));
    end
  end

  initial begin
    modelPc = '0;
    drive(1, 0, 0, 0, 0, 9'h000, 8'h00, 8'h00, '0, "R1 reset vector");
    drive(1, 0, 0, 0, 0, 9'h000, 8'h00, 8'h60, '0, "R1 reset held");
    // R2: wrap from 0x7FF to 0 with page bits set
    drive(0, 0, 0, 0, 0, 9'h000, 8'h00, 8'h60, '0, "R2 wrap to zero");
    drive(0, 0, 0, 0, 0, 9'h000, 8'h00, 8'h60, '0, "R2 step");
    // R3 + R6: jump with page 01
    drive(0, 0, 0, 1, 0, 9'h1A5, 8'h00, 8'h20, '0, "R3 R6 goto page1");
    drive(0, 0, 0, 0, 0, 9'h000, 8'h00, 8'h00, '0, "R2 after goto");
    // R4 + R6 + R8: call with bit8 set in immediate, page 10
    drive(0, 0, 1, 0, 0, 9'h1FF, 8'h00, 8'h40, '0, "R4 R6 call clears bit8");
    // R5: low-byte write with page 11
    drive(0, 0, 0, 0, 1, 9'h1FF, 8'h3C, 8'h60, '0, "R5 low-byte write");
    // R6: unrelated status bits ignored
    drive(0, 0, 0, 1, 0, 9'h0F0, 8'h00, 8'h9F, '0, "R6 other status bits");
    // R7: return ignores status
    drive(0, 1, 0, 0, 0, 9'h000, 8'h00, 8'h60, 11'h555, "R7 return full");
    drive(0, 1, 0, 0, 0, 9'h000, 8'h00, 8'h00, 11'h7FF, "R7 return top");
    drive(0, 0, 0, 0, 0, 9'h000, 8'h00, 8'h00, '0, "R2 wrap after return");
    // R9: priority cases
    drive(0, 1, 1, 1, 1, 9'h0AA, 8'h11, 8'h60, 11'h123, "R9 return beats all");
    drive(0, 0, 1, 1, 1, 9'h1AA, 8'h11, 8'h20, '0, "R9 call beats goto");
    drive(0, 0, 0, 1, 1, 9'h1AA, 8'h11, 8'h40, '0, "R9 goto beats write");
    drive(1, 1, 1, 0, 0, 9'h0AA, 8'h11, 8'h00, 11'h321, "R9 reset beats return");
    drive(0, 0, 0, 0, 1, 9'h000, 8'hFF, 8'h00, '0, "R5 write page0");
    drive(0, 0, 0, 0, 0, 9'h000, 8'h00, 8'h00, '0, "R2 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule